// File: doc/BRIEF.md
# CAN Bit Timing and Synchronization Unit

This block turns the system clock into CAN time quanta and splits every nominal bit into four parts: a one-quantum sync segment, a propagation segment, phase segment 1 and phase segment 2. It watches the receive line through a two-flop synchronizer. At the sample point, where phase segment 1 meets phase segment 2, it raises a one-clock strobe together with the bit value it sampled. It also gives a one-clock strobe at the start of every bit, which the transmit path uses to change its output.

Falling edges on the bus (recessive 1 to dominant 0) keep the local timing aligned with the bus. While the bus is idle and a start of frame is expected, an edge restarts the bit timing outright (hard synchronization). During a frame, an edge moves the sample point by at most a programmable jump width (resynchronization). A resynchronization is skipped while this node drives a dominant bit itself. Frame decoding, bit stuffing, CRC and error counting belong to the surrounding controller.

Top module: `can_bit_timing`

## Requirements
- R1: One time quantum lasts 2*(brp_i+1) system clocks, with brp_i a 6-bit value giving a prescale of 1 to 64.
- R2: With no synchronizing edges, bit_start_o pulses once every N quanta. N = 1 + (prop_i+1) + (ph1_i+1) + max(ph2_i+1, 2).
- R3: sample_o is one clock wide and comes 1+(prop_i+1)+(ph1_i+1)+ext quanta after the bit start. It is registered from the quantum tick that ends phase segment 1. rx_bit_o takes the synchronized line value at that tick and changes at no other time.
- R4: While sof_en_i is 1, a 1-to-0 change on rx_i restarts the bit at the sync segment, with the prescaler cleared. bit_start_o pulses in the third clock after the change on rx_i, counting two synchronizer flops and one output register.
- R5: When sof_en_i is 0, an edge in quantum q of the bit, with 1 <= q <= end of phase segment 1, lengthens phase segment 1 by ext = min(q, sjw_i+1).
- R6: When sof_en_i is 0, an edge in phase-segment-2 quantum k (0-based) shortens phase segment 2 by min(sjw_i+1, L2-k-1), where L2 is the nominal phase-2 length. The current quantum is always kept.
- R7: While tx_dom_i is 1, no resynchronization takes place, and the sample point and bit length stay at their nominal values.
- R8: Only one synchronization, hard or resync, is taken between two sample points. An edge inside the sync segment adjusts nothing.
- R9: Under reset sample_o and bit_start_o are 0 and rx_bit_o is 1 (recessive). After reset the bit starts at the sync segment with the prescaler at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_i | input | 1 | Raw bus receive line, 1 = recessive |
| tx_dom_i | input | 1 | This node is driving a dominant bit |
| sof_en_i | input | 1 | Bus idle; the next falling edge is a start of frame |
| brp_i | input | 6 | Prescale minus one (quantum = 2*(brp_i+1) clocks) |
| prop_i | input | 3 | Propagation segment length minus one |
| ph1_i | input | 3 | Phase segment 1 length minus one |
| ph2_i | input | 3 | Phase segment 2 length minus one, minimum length 2 |
| sjw_i | input | 2 | Jump width minus one |
| sample_o | output | 1 | One-clock strobe at the sample point |
| rx_bit_o | output | 1 | Bit value taken at the last sample point |
| bit_start_o | output | 1 | One-clock strobe at the start of each bit |

## Verification
If the segment position or the prescaler count goes wrong, the sample strobe or the bit-start strobe moves by at least one whole quantum. A clock-by-clock comparison against a behavioural model catches that in the first bit after the fault. If the jump-width adjustment or the once-per-sample-interval lock is wrong, the next sample point or bit end lands at the wrong clock. Directed edges placed in chosen quanta make that offset exact. A fault in the synchronizer or the hard-synchronization path shows up as the bit-start strobe arriving earlier or later than three clocks after the line falls.

// File: rtl/can_bt_pkg.sv
// Package: shared types for the CAN bit timing unit.
// Assumes: segments always run in the order listed in seg_e.
package can_bt_pkg;
    typedef enum logic [1:0] {
        SEG_SYNC = 2'd0,
        SEG_PROP = 2'd1,
        SEG_PH1  = 2'd2,
        SEG_PH2  = 2'd3
    } seg_e;
endpackage

// File: rtl/can_bt_rx_sync.sv
// Module: can_bt_rx_sync
// Brings the asynchronous receive line into the clock domain through a
// flop chain and flags recessive-to-dominant transitions.
// Assumes: STAGES >= 2; line idles recessive (1).
module can_bt_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_i,
    output logic rx_s_o,
    output logic fall_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    // Shift the raw line through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], rx_i};
    end

    // Keep the previous synchronized value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign rx_s_o = chain_q[STAGES-1];
    assign fall_o = prev_q & ~chain_q[STAGES-1];

    // A falling edge leaves the line low, so it cannot repeat next clock.
    assert_single_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);
endmodule

// File: rtl/can_bt_tq_gen.sv
// Module: can_bt_tq_gen
// Quantum generator: a programmable prescaler followed by a divide-by-two,
// giving a one-clock tick every 2*(brp+1) clocks. restart re-phases it.
// Assumes: brp is held stable while running.
module can_bt_tq_gen #(
    parameter int BRP_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic [BRP_W-1:0] brp_i,
    output logic             tq_tick_o
);
    logic [BRP_W-1:0] pre_q;
    logic             half_q;
    logic             pre_wrap;

    assign pre_wrap  = (pre_q >= brp_i);
    assign tq_tick_o = pre_wrap & half_q;

    // Count prescaler clocks and toggle the divide-by-two on each wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i) begin
            pre_q  <= '0;
            half_q <= 1'b0;
        end else if (pre_wrap) begin
            pre_q  <= '0;
            half_q <= ~half_q;
        end else begin
            pre_q  <= pre_q + BRP_W'(1);
        end
    end

    // The divide-by-two forbids ticks on consecutive clocks.
    assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tq_tick_o |=> !tq_tick_o);

    // A restart from the sequencer re-phases the quantum from zero.
    assert_restart_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (pre_q == '0 && !half_q));
endmodule

// File: rtl/can_bt_seq.sv
// Module: can_bt_seq
// Segment sequencer: walks sync, propagation, phase 1 and phase 2 one
// quantum at a time, applies hard sync and jump-width-limited resync,
// and registers the sample and bit-start strobes.
// Assumes: configuration is stable while out of reset; LEN_W holds
// the longest stretched phase segment.
module can_bt_seq
    import can_bt_pkg::*;
#(
    parameter int SEG_W = 3,
    parameter int SJW_W = 2,
    parameter int LEN_W = SEG_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tq_tick_i,
    input  logic             fall_i,
    input  logic             rx_s_i,
    input  logic             tx_dom_i,
    input  logic             sof_en_i,
    input  logic [SEG_W-1:0] prop_i,
    input  logic [SEG_W-1:0] ph1_i,
    input  logic [SEG_W-1:0] ph2_i,
    input  logic [SJW_W-1:0] sjw_i,
    output logic             hard_sync_o,
    output logic             sample_o,
    output logic             rx_bit_o,
    output logic             bit_start_o
);
    localparam logic [LEN_W-1:0] ONE    = LEN_W'(1);
    localparam logic [LEN_W-1:0] PH2MIN = LEN_W'(2);

    seg_e             seg_q;
    logic [LEN_W-1:0] qi_q, ph1_add_q, ph2_cut_q;
    logic             sync_done_q;
    logic [LEN_W-1:0] prop_len, ph1_nom, ph2_raw, ph2_nom, sjw_len;
    logic [LEN_W-1:0] phase_err, add_nxt, cut_nxt, seg_len, ph2_room;
    logic             resync, last_q, sample_d, bit_start_d;

    function automatic logic [LEN_W-1:0] umin(input logic [LEN_W-1:0] a,
                                              input logic [LEN_W-1:0] b);
        return (a < b) ? a : b;
    endfunction

    // Decode configured lengths; phase 2 never drops below two quanta.
    always_comb begin
        prop_len = LEN_W'(prop_i) + ONE;
        ph1_nom  = LEN_W'(ph1_i) + ONE;
        ph2_raw  = LEN_W'(ph2_i) + ONE;
        ph2_nom  = (ph2_raw < PH2MIN) ? PH2MIN : ph2_raw;
        sjw_len  = LEN_W'(sjw_i) + ONE;
    end

    // Classify the edge and measure its phase error in quanta.
    always_comb begin
        hard_sync_o = fall_i & sof_en_i & ~sync_done_q;
        resync      = fall_i & ~sof_en_i & ~tx_dom_i & ~sync_done_q
                      & (seg_q != SEG_SYNC);
        unique case (seg_q)
            SEG_PROP: phase_err = qi_q + ONE;
            SEG_PH1:  phase_err = prop_len + qi_q + ONE;
            SEG_PH2:  phase_err = ph2_nom - qi_q;
            default:  phase_err = '0;
        endcase
        ph2_room = (ph2_nom > qi_q) ? (ph2_nom - qi_q - ONE) : '0;
    end

    // Work out the adjusted phase lengths and the end of the current segment.
    always_comb begin
        add_nxt = ph1_add_q;
        cut_nxt = ph2_cut_q;
        if (resync && (seg_q == SEG_PROP || seg_q == SEG_PH1))
            add_nxt = umin(phase_err, sjw_len);
        if (resync && seg_q == SEG_PH2)
            cut_nxt = umin(sjw_len, ph2_room);
        unique case (seg_q)
            SEG_SYNC: seg_len = ONE;
            SEG_PROP: seg_len = prop_len;
            SEG_PH1:  seg_len = ph1_nom + add_nxt;
            default:  seg_len = ph2_nom - cut_nxt;
        endcase
        last_q      = (qi_q >= seg_len - ONE);
        sample_d    = tq_tick_i & last_q & (seg_q == SEG_PH1) & ~hard_sync_o;
        bit_start_d = hard_sync_o | (tq_tick_i & last_q & (seg_q == SEG_PH2));
    end

    // Advance the segment state on quantum ticks and apply synchronizations.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_q       <= SEG_SYNC;
            qi_q        <= '0;
            ph1_add_q   <= '0;
            ph2_cut_q   <= '0;
            sync_done_q <= 1'b0;
        end else if (hard_sync_o) begin
            seg_q       <= SEG_SYNC;
            qi_q        <= '0;
            ph1_add_q   <= '0;
            ph2_cut_q   <= '0;
            sync_done_q <= 1'b1;
        end else begin
            ph1_add_q <= add_nxt;
            ph2_cut_q <= cut_nxt;
            if (tq_tick_i) begin
                if (last_q) begin
                    qi_q <= '0;
                    unique case (seg_q)
                        SEG_SYNC: seg_q <= SEG_PROP;
                        SEG_PROP: seg_q <= SEG_PH1;
                        SEG_PH1: begin
                            seg_q       <= SEG_PH2;
                            sync_done_q <= 1'b0;
                        end
                        default: begin
                            seg_q     <= SEG_SYNC;
                            ph1_add_q <= '0;
                            ph2_cut_q <= '0;
                        end
                    endcase
                end else begin
                    qi_q <= qi_q + ONE;
                end
            end
            if (resync) sync_done_q <= 1'b1;
        end
    end

    // Register the strobes and hold the sampled bit between sample points.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_o    <= 1'b0;
            bit_start_o <= 1'b0;
            rx_bit_o    <= 1'b1;
        end else begin
            sample_o    <= sample_d;
            bit_start_o <= bit_start_d;
            if (sample_d) rx_bit_o <= rx_s_i;
        end
    end

    assert_ext_capped_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ph1_add_q <= sjw_len);

    assert_cut_capped_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ph2_cut_q <= sjw_len);

    assert_strobes_apart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bit_start_o |-> !sample_o);

    assert_bit_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_bit_o) |-> sample_o);
endmodule

// File: rtl/can_bit_timing.sv
// Module: can_bit_timing (top)
// CAN bit timing unit: quantum generation, segment sequencing, edge
// synchronization, sample strobe and bit-start strobe.
// Assumes: configuration inputs change only while in reset.
module can_bit_timing #(
    parameter int BRP_W       = 6,
    parameter int SEG_W       = 3,
    parameter int SJW_W       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_i,
    input  logic             tx_dom_i,
    input  logic             sof_en_i,
    input  logic [BRP_W-1:0] brp_i,
    input  logic [SEG_W-1:0] prop_i,
    input  logic [SEG_W-1:0] ph1_i,
    input  logic [SEG_W-1:0] ph2_i,
    input  logic [SJW_W-1:0] sjw_i,
    output logic             sample_o,
    output logic             rx_bit_o,
    output logic             bit_start_o
);
    localparam int LEN_W = SEG_W + 2;

    logic rx_s, fall, tq_tick, hard_sync;

    can_bt_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .rx_i   (rx_i),
        .rx_s_o (rx_s),
        .fall_o (fall)
    );

    can_bt_tq_gen #(.BRP_W(BRP_W)) u_tq (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (hard_sync),
        .brp_i     (brp_i),
        .tq_tick_o (tq_tick)
    );

    can_bt_seq #(.SEG_W(SEG_W), .SJW_W(SJW_W), .LEN_W(LEN_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .tq_tick_i   (tq_tick),
        .fall_i      (fall),
        .rx_s_i      (rx_s),
        .tx_dom_i    (tx_dom_i),
        .sof_en_i    (sof_en_i),
        .prop_i      (prop_i),
        .ph1_i       (ph1_i),
        .ph2_i       (ph2_i),
        .sjw_i       (sjw_i),
        .hard_sync_o (hard_sync),
        .sample_o    (sample_o),
        .rx_bit_o    (rx_bit_o),
        .bit_start_o (bit_start_o)
    );
endmodule

// File: tb/can_bit_timing_tb.sv
module can_bit_timing_tb_top;
    logic       clk = 1'b0;
    logic       rst_n, rx, tx_dom, sof_en;
    logic [5:0] brp;
    logic [2:0] prop, ph1, ph2;
    logic [1:0] sjw;
    logic       sample, rxbit, bstart;
    int         total = 0, bad = 0, cyc = 0;
    bit         finished = 0;

    always #5 clk = ~clk;

    can_bit_timing dut_i (
        .clk(clk), .rst_n(rst_n), .rx_i(rx), .tx_dom_i(tx_dom), .sof_en_i(sof_en),
        .brp_i(brp), .prop_i(prop), .ph1_i(ph1), .ph2_i(ph2), .sjw_i(sjw),
        .sample_o(sample), .rx_bit_o(rxbit), .bit_start_o(bstart)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Behavioural reference: quantum position within the bit as an integer.
    int m_cnt, m_q, m_ext, m_cut, m_s1, m_s2, m_s3;
    bit m_done;
    int exp_sample, exp_bit, exp_bs;

    always @(posedge clk) begin
        int tq, p, a, l2, s, idx;
        bit fall, tick, hs, rs, ns, nbs;
        if (!rst_n) begin
            m_cnt = 0; m_q = 0; m_ext = 0; m_cut = 0; m_done = 0;
            m_s1 = 1; m_s2 = 1; m_s3 = 1;
            exp_sample = 0; exp_bit = 1; exp_bs = 0;
        end else begin
            tq = 2 * (int'(brp) + 1);
            p  = int'(prop) + 1;
            a  = int'(ph1) + 1;
            l2 = (int'(ph2) + 1 < 2) ? 2 : int'(ph2) + 1;
            s  = int'(sjw) + 1;
            fall = (m_s3 == 1) && (m_s2 == 0);
            tick = (m_cnt == tq - 1);
            hs = fall && sof_en && !m_done;
            rs = fall && !sof_en && !tx_dom && !m_done && (m_q != 0);
            ns = 0; nbs = 0;
            if (hs) begin
                m_q = 0; m_ext = 0; m_cut = 0; m_done = 1; m_cnt = 0; nbs = 1;
            end else begin
                if (rs) begin
                    m_done = 1;
                    if (m_q <= p + a + m_ext) m_ext = (m_q < s) ? m_q : s;
                    else begin
                        idx = m_q - (p + a + m_ext + 1);
                        m_cut = (s < l2 - idx - 1) ? s : l2 - idx - 1;
                    end
                end
                if (tick) begin
                    m_cnt = 0;
                    if (m_q == p + a + m_ext) begin ns = 1; m_done = 0; end
                    if (m_q == p + a + m_ext + l2 - m_cut) begin
                        nbs = 1; m_q = 0; m_ext = 0; m_cut = 0;
                    end else m_q++;
                end else m_cnt++;
            end
            exp_sample = ns;
            if (ns) exp_bit = m_s2;
            exp_bs = nbs;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = rx;
        end
    end

    // Compare every clock, shortly after the edge.
    always @(posedge clk) begin
        #2;
        if (!finished) begin
            check("R3", "sample_o", sample, exp_sample);
            check("R3", "rx_bit_o", rxbit, exp_bit);
            check("R2", "bit_start_o", bstart, exp_bs);
        end
    end

    task automatic apply_cfg(input int b, input int pr, input int p1, input int p2,
                             input int sj, input bit sof);
        @(negedge clk);
        rst_n = 0; rx = 1; tx_dom = 0; sof_en = sof;
        brp = 6'(b); prop = 3'(pr); ph1 = 3'(p1); ph2 = 3'(p2); sjw = 2'(sj);
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic wait_bs();
        int n = 0;
        do begin @(posedge clk); #2; n++; end while (!bstart && n < 10000);
        if (!bstart) begin total++; bad++; $display("FAIL R2 bit_start timeout: actual=0 expected=1"); end
    endtask

    task automatic wait_sample();
        int n = 0;
        do begin @(posedge clk); #2; n++; end while (!sample && n < 10000);
        if (!sample) begin total++; bad++; $display("FAIL R3 sample timeout: actual=0 expected=1"); end
    endtask

    task automatic drive_at(input int target, input logic v);
        @(negedge clk);
        while (cyc < target) @(negedge clk);
        rx = v;
    endtask

    // Edge in quantum q, measure clocks from bit start to sample strobe.
    task automatic probe_sample(input string tag, input int q, input bit txd, input int exp);
        int t0;
        tx_dom = txd;
        wait_bs(); t0 = cyc;
        drive_at(t0 + 4 * q, 1'b0);
        wait_sample();
        check(tag, "bit start to sample", cyc - t0, exp);
        @(negedge clk); rx = 1; tx_dom = 0;
    endtask

    // Edge in quantum q, measure clocks to the next bit start.
    task automatic probe_bit(input string tag, input int q, input int exp);
        int t0;
        wait_bs(); t0 = cyc;
        drive_at(t0 + 4 * q, 1'b0);
        wait_bs();
        check(tag, "bit length", cyc - t0, exp);
        @(negedge clk); rx = 1;
    endtask

    initial begin
        int t, c;
        rst_n = 0; rx = 1; tx_dom = 0; sof_en = 1;
        brp = 6'd4; prop = 3'd0; ph1 = 3'd0; ph2 = 3'd0; sjw = 2'd0;
        repeat (3) @(negedge clk);
        check("R9", "reset sample_o", sample, 0);
        check("R9", "reset bit_start_o", bstart, 0);
        check("R9", "reset rx_bit_o", rxbit, 1);
        rst_n = 1;

        // Quantum of 10 clocks, bit 1+1+1+2 quanta (phase 2 clamped).
        wait_bs(); t = cyc; wait_bs();
        check("R1", "idle bit period", cyc - t, 50);
        repeat (20) @(negedge clk);
        rx = 0; c = cyc;
        wait_bs();
        check("R4", "hard sync latency", cyc - c, 3);
        t = cyc; wait_sample();
        check("R4", "sample after hard sync", cyc - t, 30);
        check("R3", "sampled dominant", rxbit, 0);
        @(negedge clk); rx = 1;

        // Quantum 4 clocks, prop 2, ph1 3, ph2 3, jump width 2, in frame.
        apply_cfg(1, 1, 2, 2, 1, 0);
        probe_sample("R5", 1, 0, 28);
        probe_sample("R5", 4, 0, 32);
        probe_sample("R7", 1, 1, 24);
        probe_sample("R8", 0, 0, 24);
        probe_bit("R6", 6, 28);
        probe_bit("R6", 7, 32);
        begin
            int t0;
            wait_bs(); t0 = cyc;
            drive_at(t0 + 4, 1'b0);
            drive_at(t0 + 8, 1'b1);
            drive_at(t0 + 12, 1'b0);
            wait_sample();
            check("R8", "second edge ignored", cyc - t0, 28);
            @(negedge clk); rx = 1;
        end

        // Random traffic against the reference model.
        apply_cfg(0, 0, 1, 1, 1, 1);
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if ($urandom_range(0, 7) == 0) rx = ~rx;
            if ($urandom_range(0, 63) == 0) sof_en = ~sof_en;
            tx_dom = ($urandom_range(0, 3) == 0);
        end
        apply_cfg(2, 3, 2, 0, 3, 0);
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if ($urandom_range(0, 11) == 0) rx = ~rx;
            if ($urandom_range(0, 99) == 0) sof_en = ~sof_en;
            tx_dom = ($urandom_range(0, 4) == 0);
        end

        // Largest prescale and longest segments.
        apply_cfg(63, 7, 7, 7, 3, 1);
        wait_bs(); t = cyc; wait_bs();
        check("R2", "long bit period", cyc - t, 3200);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL R2 watchdog expired: actual=%0d expected=<150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule